// File: doc/BRIEF.md
# Configuration ROM Checksum Engine

This block computes the two integrity values that a 128-byte configuration ROM image carries. The image arrives as a byte stream, lowest address first. Two checksums are accumulated on the fly. One is an 8-bit identification CRC over the leading part of the image, whose result belongs in byte 16. The other is a 16-bit checksum derived from a 32-bit CRC over bytes 0 to 125, whose result belongs in bytes 126 and 127. Because the 32-bit CRC must see the image with the identification CRC already in place, the engine substitutes that value for whatever arrives as byte 16.

A one-cycle start pulse arms the engine and clears both CRC registers. Bytes are then taken one per clock on a valid/ready handshake. Eight CRC bit steps per byte are unrolled in combinational logic. Bytes travel in pairs that form little-endian 16-bit words, so each pair is folded into the CRCs when its odd byte arrives. After byte 125 is taken, the engine raises a done pulse for one cycle and publishes both results. It then refuses further bytes until the next start.

Top module: `rom_cksum_engine`

## Requirements
- R1: After reset, in_ready and done are 0 and both id_crc and rom_sum read 0.
- R2: in_ready is 0 in any cycle where start is 1, so a byte offered alongside start is not taken. in_ready is 1 from the cycle after a start pulse until the final byte is taken.
- R3: A byte is taken only on a cycle where in_valid and in_ready are both 1. Idle cycles between bytes do not change the results.
- R4: The identification CRC starts at 0xFF. It processes the image as little-endian 16-bit words (word w = byte 2w+1 in bits 15..8, byte 2w in bits 7..0), each from bit 15 down to bit 0. Each bit step computes feedback = data bit XOR CRC bit 7 and shifts the CRC left. When feedback is 1, the step XORs the CRC with 0x06 and forces bit 0 to 1. Words 0 to 7 are covered fully, and word 8 only in bits 15..8 (byte 17). Byte 16 has no influence on id_crc.
- R5: The 32-bit CRC starts at 0xFFFFFFFF and processes bytes 0 to 125, each from bit 0 to bit 7. Each bit step computes feedback = old bit 31 XOR data bit and shifts left. When feedback is 1, the step XORs the CRC with 0x04C11DB6 and forces bit 0 to 1. Byte 16 is replaced by the identification CRC before it enters this CRC.
- R6: rom_sum is the final 32-bit CRC with its bit order reversed, all bits inverted, and then truncated to the low 16 bits.
- R7: done is 1 for exactly one cycle, the cycle after byte 125 is taken. in_ready is 0 in that cycle.
- R8: Once the image is complete, bytes offered with in_valid are ignored: in_ready stays 0, done stays 0, and the outputs keep their values.
- R9: id_crc and rom_sum change only in a cycle where done is 1, and they hold their values until the next completed image.
- R10: A start pulse in the middle of an image discards the bytes taken so far and restarts at byte 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle pulse that arms the engine for a new image |
| in_valid | input | 1 | A byte is offered on in_byte |
| in_byte | input | 8 | Image byte, lowest address first |
| in_ready | output | 1 | Engine accepts a byte this cycle |
| done | output | 1 | One-cycle pulse when both results are published |
| id_crc | output | 8 | Identification CRC, destined for byte 16 |
| rom_sum | output | 16 | Image checksum, destined for bytes 126 and 127 |

## Verification
The bench feeds pairs of images that differ only in byte 16 and expects identical results. A design that hashed the raw byte 16 instead of substituting the identification CRC would split those results. Images run both without gaps and with idle cycles between bytes, which catches a byte counter that advances without a handshake. The bench also offers a byte in the same cycle as start, and issues a start partway through an image. A design that took the byte offered with start, or kept the earlier partial state, would produce checksums that disagree with the reference computed in the bench. Bytes offered after completion must raise neither in_ready nor done, and must leave both results untouched.

// File: rtl/rom_cksum_pkg.sv
package rom_cksum_pkg;

  // One byte through the identification CRC, data bit 7 first.
  function automatic logic [7:0] id_step(input logic [7:0] c_in, input logic [7:0] b);
    logic [7:0] c;
    logic fb;
    c = c_in;
    for (int i = 7; i >= 0; i--) begin
      fb = b[i] ^ c[7];
      c = {c[6:0], 1'b0};
      if (fb) begin
        c = c ^ 8'h06;
        c[0] = 1'b1;
      end
    end
    return c;
  endfunction

  // One byte through the 32-bit CRC, data bit 0 first.
  function automatic logic [31:0] wide_step(input logic [31:0] c_in, input logic [7:0] b);
    logic [31:0] c;
    logic fb;
    c = c_in;
    for (int i = 0; i < 8; i++) begin
      fb = c[31] ^ b[i];
      c = {c[30:0], 1'b0};
      if (fb) begin
        c = c ^ 32'h04C1_1DB6;
        c[0] = 1'b1;
      end
    end
    return c;
  endfunction

  // Reverse, invert, keep the low half.
  function automatic logic [15:0] wide_fold(input logic [31:0] c);
    logic [31:0] r;
    for (int i = 0; i < 32; i++) r[31-i] = c[i];
    return ~r[15:0];
  endfunction

endpackage

// File: rtl/rom_cksum_id_unit.sv
module rom_cksum_id_unit
  import rom_cksum_pkg::*;
#(
  parameter int IDX_W      = 7,
  parameter int FULL_BYTES = 16,
  parameter int HI_IDX     = 17
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             acc,
  input  logic [IDX_W-1:0] idx,
  input  logic [7:0]       byte_i,
  output logic [7:0]       id_o,
  output logic [7:0]       id_sub_o
);
  logic [7:0] id_q, lo_q;
  logic       pair_full, pair_high_only;

  assign pair_full      = acc && idx[0] && (int'(idx) < FULL_BYTES);
  assign pair_high_only = acc && (int'(idx) == HI_IDX);
  assign id_sub_o       = id_step(id_q, byte_i);
  assign id_o           = id_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      id_q <= 8'hFF;
      lo_q <= 8'h00;
    end else if (clr) begin
      id_q <= 8'hFF;
      lo_q <= 8'h00;
    end else if (acc) begin
      if (!idx[0]) lo_q <= byte_i;
      if (pair_full)           id_q <= id_step(id_step(id_q, byte_i), lo_q);
      else if (pair_high_only) id_q <= id_sub_o;
    end
  end

  // R4
  id_beyond_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !clr && int'(idx) > HI_IDX) |=> $stable(id_q));

endmodule

// File: rtl/rom_cksum_wide_unit.sv
module rom_cksum_wide_unit
  import rom_cksum_pkg::*;
#(
  parameter int IDX_W   = 7,
  parameter int SUB_IDX = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             acc,
  input  logic [IDX_W-1:0] idx,
  input  logic [7:0]       byte_i,
  input  logic [7:0]       id_sub,
  output logic [31:0]      crc_next_o
);
  logic [31:0] crc_q;
  logic [7:0]  lo_q, lo_eff;
  logic        pair_go;

  assign pair_go = acc && idx[0];
  assign lo_eff  = (int'(idx) == SUB_IDX + 1) ? id_sub : lo_q;

  always_comb begin
    crc_next_o = crc_q;
    if (pair_go) crc_next_o = wide_step(wide_step(crc_q, lo_eff), byte_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      crc_q <= 32'hFFFF_FFFF;
      lo_q  <= 8'h00;
    end else if (clr) begin
      crc_q <= 32'hFFFF_FFFF;
      lo_q  <= 8'h00;
    end else if (acc) begin
      if (!idx[0]) lo_q <= byte_i;
      crc_q <= crc_next_o;
    end
  end

  // R3
  wide_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!acc && !clr) |=> $stable(crc_q));

  // R5
  wide_even_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !clr && !idx[0]) |=> $stable(crc_q));

endmodule

// File: rtl/rom_cksum_engine.sv
module rom_cksum_engine
  import rom_cksum_pkg::*;
#(
  parameter int IMG_BYTES  = 126,
  parameter int ID_BYTES   = 16,
  parameter int ID_SLOT    = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic        in_valid,
  input  logic [7:0]  in_byte,
  output logic        in_ready,
  output logic        done,
  output logic [7:0]  id_crc,
  output logic [15:0] rom_sum
);
  localparam int IDX_W  = $clog2(IMG_BYTES + 1);
  localparam int HI_IDX = ID_SLOT + 1;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(IMG_BYTES - 1);

  logic             running;
  logic [IDX_W-1:0] idx;
  logic             accept, last_take;
  logic [7:0]       id_now, id_sub;
  logic [31:0]      crc_next;

  assign in_ready  = running && !start;
  assign accept    = in_valid && in_ready;
  assign last_take = accept && (idx == LAST_IDX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running <= 1'b0;
      idx     <= '0;
      done    <= 1'b0;
      id_crc  <= 8'h00;
      rom_sum <= 16'h0000;
    end else begin
      done <= last_take;
      if (start) begin
        running <= 1'b1;
        idx     <= '0;
      end else if (accept) begin
        idx <= idx + 1'b1;
        if (last_take) begin
          running <= 1'b0;
          id_crc  <= id_now;
          rom_sum <= wide_fold(crc_next);
        end
      end
    end
  end

  rom_cksum_id_unit #(
    .IDX_W(IDX_W), .FULL_BYTES(ID_BYTES), .HI_IDX(HI_IDX)
  ) u_id (
    .clk(clk), .rst_n(rst_n), .clr(start), .acc(accept), .idx(idx),
    .byte_i(in_byte), .id_o(id_now), .id_sub_o(id_sub)
  );

  rom_cksum_wide_unit #(
    .IDX_W(IDX_W), .SUB_IDX(ID_SLOT)
  ) u_wide (
    .clk(clk), .rst_n(rst_n), .clr(start), .acc(accept), .idx(idx),
    .byte_i(in_byte), .id_sub(id_sub), .crc_next_o(crc_next)
  );

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R7
  done_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !in_ready);

  // R2
  start_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (running && idx == '0));

  // R9
  hold_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> ($stable(rom_sum) && $stable(id_crc)));

  // R8
  idx_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    running |-> (idx <= LAST_IDX));

endmodule

// File: tb/rom_cksum_engine_test.sv
module rom_cksum_engine_test;
  localparam int CLK_PERIOD = 10;
  localparam int NB = 126;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, in_valid = 1'b0;
  logic [7:0] in_byte = 8'h00;
  logic in_ready, done;
  logic [7:0] id_crc;
  logic [15:0] rom_sum;

  int total = 0, bad = 0, cycles = 0;
  logic [7:0] img [128];

  rom_cksum_engine uut (
    .clk(clk), .rst_n(rst_n), .start(start), .in_valid(in_valid),
    .in_byte(in_byte), .in_ready(in_ready), .done(done),
    .id_crc(id_crc), .rom_sum(rom_sum)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Reference: word-wise identification CRC with the equivalent 0x07 form,
  // then byte-wise 32-bit CRC with the equivalent 0x04C11DB7 form.
  task automatic reference(output logic [7:0] rid, output logic [15:0] rsum);
    logic [7:0] c8;
    logic [31:0] c32, rv;
    logic [15:0] w;
    logic [7:0] cp [128];
    logic fb;
    c8 = 8'hFF;
    for (int wi = 0; wi < 9; wi++) begin
      w = {img[2*wi+1], img[2*wi]};
      for (int b = 15; b >= 0; b--) begin
        if (wi == 8 && b == 7) break;
        fb = w[b] ^ c8[7];
        c8 = (c8 << 1) ^ (fb ? 8'h07 : 8'h00);
      end
    end
    rid = c8;
    for (int i = 0; i < 128; i++) cp[i] = img[i];
    cp[16] = c8;
    c32 = 32'hFFFF_FFFF;
    for (int i = 0; i < NB; i++)
      for (int b = 0; b < 8; b++) begin
        fb = c32[31] ^ cp[i][b];
        c32 = (c32 << 1) ^ (fb ? 32'h04C1_1DB7 : 32'h0);
      end
    for (int i = 0; i < 32; i++) rv[i] = c32[31-i];
    rsum = ~rv[15:0];
  endtask

  task automatic pulse_start();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  // Sends bytes [from, upto) of img; gap idle cycles before each byte.
  task automatic send(input int from, input int upto, input int gap);
    for (int i = from; i < upto; i++) begin
      for (int g = 0; g < gap; g++) begin
        @(negedge clk); in_valid = 1'b0; in_byte = 8'hA5;
      end
      @(negedge clk); in_valid = 1'b1; in_byte = img[i];
      @(posedge clk);
    end
    @(negedge clk); in_valid = 1'b0;
  endtask

  task automatic run_image(input string tag, input int gap);
    logic [7:0] eid; logic [15:0] esum;
    reference(eid, esum);
    pulse_start();
    send(0, NB, gap);
    #1;
    chk({tag, " R7 done"}, done, 1);
    chk({tag, " R7 ready low"}, in_ready, 0);
    chk({tag, " R4 id_crc"}, id_crc, eid);
    chk({tag, " R5 R6 rom_sum"}, rom_sum, esum);
    @(negedge clk); #1;
    chk({tag, " R7 single pulse"}, done, 0);
  endtask

  task automatic fill_ramp(input int mul, input int add);
    for (int i = 0; i < 128; i++) img[i] = 8'(i * mul + add);
  endtask

  task automatic fill_lfsr(input logic [15:0] seed);
    logic [15:0] s;
    s = seed;
    for (int i = 0; i < 128; i++) begin
      s = {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
      img[i] = s[7:0];
    end
  endtask

  task automatic t_reset();
    #1;
    chk("R1 ready", in_ready, 0);
    chk("R1 done", done, 0);
    chk("R1 id", id_crc, 0);
    chk("R1 sum", rom_sum, 0);
  endtask

  task automatic t_byte16_excluded();
    logic [7:0] id_a; logic [15:0] sum_a;
    fill_lfsr(16'h1D2B);
    img[16] = 8'h00;
    run_image("b16a", 0);
    id_a = id_crc; sum_a = rom_sum;
    img[16] = 8'hC3;
    run_image("b16b", 0);
    chk("R4 byte16 no effect on id", id_crc, id_a);
    chk("R5 byte16 replaced", rom_sum, sum_a);
  endtask

  task automatic t_start_with_byte();
    logic [7:0] eid; logic [15:0] esum;
    fill_ramp(13, 7);
    reference(eid, esum);
    @(negedge clk); start = 1'b1; in_valid = 1'b1; in_byte = 8'h5A;
    #1; chk("R2 ready low with start", in_ready, 0);
    @(negedge clk); start = 1'b0; in_valid = 1'b0;
    #1; chk("R2 ready after start", in_ready, 1);
    send(0, NB, 0);
    #1;
    chk("R2 done", done, 1);
    chk("R2 id", id_crc, eid);
    chk("R2 sum", rom_sum, esum);
  endtask

  task automatic t_restart();
    logic [7:0] eid; logic [15:0] esum;
    fill_lfsr(16'hBEEF);
    pulse_start();
    send(0, 40, 0);
    fill_ramp(3, 200);
    reference(eid, esum);
    pulse_start();
    send(0, NB, 0);
    #1;
    chk("R10 done", done, 1);
    chk("R10 id", id_crc, eid);
    chk("R10 sum", rom_sum, esum);
  endtask

  task automatic t_after_done();
    logic [7:0] hid; logic [15:0] hsum;
    logic saw;
    @(negedge clk);
    hid = id_crc; hsum = rom_sum; saw = 1'b0;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk); in_valid = 1'b1; in_byte = 8'(i * 31);
      #1; if (in_ready) saw = 1'b1;
      if (done) saw = 1'b1;
    end
    @(negedge clk); in_valid = 1'b0; #1;
    chk("R8 no ready or done", saw, 0);
    chk("R8 R9 id held", id_crc, hid);
    chk("R8 R9 sum held", rom_sum, hsum);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        bad++; total++;
        $display("FAIL watchdog actual=%0d expected=<150000", cycles);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    for (int i = 0; i < 128; i++) img[i] = 8'h00;
    run_image("zero R4 R5", 0);
    for (int i = 0; i < 128; i++) img[i] = 8'hFF;
    run_image("ones R4 R5", 0);
    fill_ramp(1, 0);
    run_image("ramp R6", 0);
    fill_lfsr(16'hACE1);
    run_image("gaps R3", 2);
    t_after_done();
    t_byte16_excluded();
    t_start_with_byte();
    t_restart();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule